// File: doc/BRIEF.md
# DMA Channel Interrupt Register Bank

This block gathers completion events from a set of DMA channel engines and turns them into interrupt state that software can see and clear. Each channel owns a four-bit slot inside a 32-bit word, eight channels to a word. The slot holds three event kinds: half of the transfer moved, one descriptor finished, and the whole descriptor chain finished. Every event kind has an enable bit and a pending bit. A single interrupt line goes high while any pending bit is also enabled.

Software reaches the enable words, the pending words and a global busy-status word through a simple 32-bit register port. Pending bits are cleared by writing ones. Channel engines drive one-cycle event pulses and a per-channel active flag. The block does not bridge to any bus protocol and does not process descriptors.

Top module: `dmairq_bank`

## Requirements
- R1: After reset, every enable and pending bit is zero, `irq` is low, `acc_rvalid` is low, and reads of all defined offsets return zero while `ch_active` is zero.
- R2: A one-cycle pulse on `ev_half[c]`, `ev_desc[c]` or `ev_chain[c]` sets pending bit `4*(c%8)+k` of the pending word at offset 0x10 (channels 0 to 7) or 0x14 (channels 8 to 15). Here k is 0 for half-done, 1 for descriptor-done and 2 for chain-done. Several pulses in one cycle set all of their bits.
- R3: An event sets its pending bit whatever the enable bit holds. With no enable bit set, `irq` stays low.
- R4: A write to offset 0x00 (channels 0 to 7) or 0x04 (channels 8 to 15) stores the enable word. Bit 3 of every nibble is reserved and always reads zero, so the writable mask is 0x77777777.
- R5: A write to a pending word clears exactly the bits that are one in the written data and leaves the other bits unchanged.
- R6: When an event pulse and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R7: `irq` is high exactly when some pending bit and its enable bit are both one. It follows the clock edge that changes either bit.
- R8: A read of offset 0x30 returns `ch_active` in bits 15:0 and zero above. Writes to 0x30 change no register.
- R9: Reads of any other offset return zero. Writes to any other offset change no register.
- R10: `acc_rvalid` is high for exactly one cycle, the cycle after each read request, with `acc_rdata` holding the addressed word. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_half | input | 16 | Per-channel half-transfer event pulse |
| ev_desc | input | 16 | Per-channel descriptor-finished event pulse |
| ev_chain | input | 16 | Per-channel chain-finished event pulse |
| ch_active | input | 16 | Per-channel busy flag, reported in the status word |
| acc_en | input | 1 | Register access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte offset of the register |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid with `acc_rvalid` |
| acc_rvalid | output | 1 | Read response strobe, one cycle after the read request |
| irq | output | 1 | Combined interrupt line |

## Verification
An event pulse or a register write changes the enable and pending state at the first rising edge that samples it. `irq` follows at that same edge, because it is decoded from the registers with no added stage. Read data and its strobe come out one edge after the request. The bench drives every stimulus on a falling edge and samples at the next falling edge: `irq` is compared after each event or write, and a monitor matches each read response against a queue of expected words that the driver filled when it issued the read. Because the response must arrive in that exact cycle, a response that comes late, comes early or never comes shows up as a mismatch or as a missing or unexpected queue entry.

// File: rtl/dmairq_pkg.sv
`timescale 1ns/1ps
package dmairq_pkg;
  localparam int REG_W     = 32;
  localparam int WORD_STEP = 4;
  localparam int EN_BASE   = 'h00;
  localparam int PEND_BASE = 'h10;
  localparam int STAT_OFS  = 'h30;

  typedef enum int {
    EV_HALF  = 0,
    EV_DESC  = 1,
    EV_CHAIN = 2
  } ev_kind_e;

  function automatic logic [REG_W-1:0] slot_mask(int cpr, int slot_w, int ev_w);
    logic [REG_W-1:0] m;
    m = '0;
    for (int c = 0; c < cpr; c++)
      for (int k = 0; k < ev_w; k++)
        m[c*slot_w + k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dmairq_event_pack.sv
`timescale 1ns/1ps
module dmairq_event_pack
  import dmairq_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int CH_PER_REG = 8,
  parameter int SLOT_W     = 4,
  parameter int NUM_REG    = 2
) (
  input  logic [NUM_CH-1:0]              ev_half,
  input  logic [NUM_CH-1:0]              ev_desc,
  input  logic [NUM_CH-1:0]              ev_chain,
  output logic [NUM_REG-1:0][REG_W-1:0]  set_words
);
  // scatter each channel's three event kinds into its nibble
  always_comb begin
    set_words = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      set_words[c/CH_PER_REG][(c%CH_PER_REG)*SLOT_W + int'(EV_HALF)]  = ev_half[c];
      set_words[c/CH_PER_REG][(c%CH_PER_REG)*SLOT_W + int'(EV_DESC)]  = ev_desc[c];
      set_words[c/CH_PER_REG][(c%CH_PER_REG)*SLOT_W + int'(EV_CHAIN)] = ev_chain[c];
    end
  end
endmodule

// File: rtl/dmairq_word.sv
`timescale 1ns/1ps
module dmairq_word
  import dmairq_pkg::*;
#(
  parameter logic [REG_W-1:0] MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             pend_clr_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] set_word,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] pend_q
);
  logic [REG_W-1:0] clr_bits;

  assign clr_bits = pend_clr_wr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_wr)
        en_q <= wdata & MASK;
      // a new event wins over a same-cycle clear
      pend_q <= ((pend_q & ~clr_bits) | set_word) & MASK;
    end
  end
endmodule

// File: rtl/dmairq_readback.sv
`timescale 1ns/1ps
module dmairq_readback
  import dmairq_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int NUM_REG = 2,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NUM_REG-1:0][REG_W-1:0] en_words,
  input  logic [NUM_REG-1:0][REG_W-1:0] pend_words,
  input  logic [NUM_CH-1:0]             ch_active,
  output logic [REG_W-1:0]              rd_word
);
  always_comb begin
    rd_word = '0;
    if (addr == ADDR_W'(STAT_OFS))
      rd_word[NUM_CH-1:0] = ch_active;
    for (int r = 0; r < NUM_REG; r++) begin
      if (addr == ADDR_W'(EN_BASE + WORD_STEP*r))
        rd_word = en_words[r];
      if (addr == ADDR_W'(PEND_BASE + WORD_STEP*r))
        rd_word = pend_words[r];
    end
  end
endmodule

// File: rtl/dmairq_bank.sv
`timescale 1ns/1ps
module dmairq_bank
  import dmairq_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int CH_PER_REG = 8,
  parameter int SLOT_W     = 4,
  parameter int EV_W       = 3,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ev_half,
  input  logic [NUM_CH-1:0] ev_desc,
  input  logic [NUM_CH-1:0] ev_chain,
  input  logic [NUM_CH-1:0] ch_active,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [REG_W-1:0]  acc_wdata,
  output logic [REG_W-1:0]  acc_rdata,
  output logic              acc_rvalid,
  output logic              irq
);
  localparam int NUM_REG = NUM_CH / CH_PER_REG;
  localparam logic [REG_W-1:0] SLOT_MASK = slot_mask(CH_PER_REG, SLOT_W, EV_W);

  logic [NUM_REG-1:0][REG_W-1:0] set_words;
  logic [NUM_REG-1:0][REG_W-1:0] en_words;
  logic [NUM_REG-1:0][REG_W-1:0] pend_words;
  logic [NUM_REG-1:0]            en_wr;
  logic [NUM_REG-1:0]            clr_wr;
  logic [REG_W-1:0]              rd_word;

  dmairq_event_pack #(
    .NUM_CH(NUM_CH), .CH_PER_REG(CH_PER_REG), .SLOT_W(SLOT_W), .NUM_REG(NUM_REG)
  ) u_pack (
    .ev_half(ev_half), .ev_desc(ev_desc), .ev_chain(ev_chain), .set_words(set_words)
  );

  always_comb begin
    for (int r = 0; r < NUM_REG; r++) begin
      en_wr[r]  = acc_en && acc_we && (acc_addr == ADDR_W'(EN_BASE + WORD_STEP*r));
      clr_wr[r] = acc_en && acc_we && (acc_addr == ADDR_W'(PEND_BASE + WORD_STEP*r));
    end
  end

  for (genvar r = 0; r < NUM_REG; r++) begin : g_word
    dmairq_word #(.MASK(SLOT_MASK)) u_word (
      .clk(clk), .rst_n(rst_n),
      .en_wr(en_wr[r]), .pend_clr_wr(clr_wr[r]),
      .wdata(acc_wdata), .set_word(set_words[r]),
      .en_q(en_words[r]), .pend_q(pend_words[r])
    );
  end

  dmairq_readback #(
    .NUM_CH(NUM_CH), .NUM_REG(NUM_REG), .ADDR_W(ADDR_W)
  ) u_rb (
    .addr(acc_addr), .en_words(en_words), .pend_words(pend_words),
    .ch_active(ch_active), .rd_word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_rdata  <= '0;
      acc_rvalid <= 1'b0;
    end else begin
      acc_rvalid <= acc_en && !acc_we;
      if (acc_en && !acc_we)
        acc_rdata <= rd_word;
    end
  end

  always_comb begin
    irq = 1'b0;
    for (int r = 0; r < NUM_REG; r++)
      irq = irq | (|(en_words[r] & pend_words[r]));
  end
endmodule

// File: rtl/dmairq_chk.sv
`timescale 1ns/1ps
module dmairq_chk
  import dmairq_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int CH_PER_REG = 8,
  parameter int SLOT_W     = 4,
  parameter int ADDR_W     = 8,
  parameter int NUM_REG    = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_CH-1:0]             ev_half,
  input logic [NUM_CH-1:0]             ev_desc,
  input logic [NUM_CH-1:0]             ev_chain,
  input logic [NUM_CH-1:0]             ch_active,
  input logic                          acc_en,
  input logic                          acc_we,
  input logic [ADDR_W-1:0]             acc_addr,
  input logic [REG_W-1:0]              acc_rdata,
  input logic                          acc_rvalid,
  input logic                          irq,
  input logic [NUM_REG-1:0][REG_W-1:0] pend_words
);
  logic known_addr;
  logic any_event;

  always_comb begin
    known_addr = (acc_addr == ADDR_W'(STAT_OFS));
    for (int r = 0; r < NUM_REG; r++)
      known_addr = known_addr || (acc_addr == ADDR_W'(EN_BASE + WORD_STEP*r))
                              || (acc_addr == ADDR_W'(PEND_BASE + WORD_STEP*r));
  end

  assign any_event = (|ev_half) || (|ev_desc) || (|ev_chain);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ev
    // R2 R6
    half_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_half[c] |=> pend_words[c/CH_PER_REG][(c%CH_PER_REG)*SLOT_W + 0]);
    // R2 R6
    desc_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_desc[c] |=> pend_words[c/CH_PER_REG][(c%CH_PER_REG)*SLOT_W + 1]);
    // R2 R6
    chain_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_chain[c] |=> pend_words[c/CH_PER_REG][(c%CH_PER_REG)*SLOT_W + 2]);
  end

  for (genvar r = 0; r < NUM_REG; r++) begin : g_clr
    // R5
    pend_clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(pend_words[r]) & ~pend_words[r])) |->
        $past(acc_en && acc_we && (acc_addr == ADDR_W'(PEND_BASE + WORD_STEP*r))));
  end

  // R7
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(any_event || (acc_en && acc_we)));

  // R8
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we && acc_addr == ADDR_W'(STAT_OFS)) |=>
      (acc_rdata == REG_W'($past(ch_active))));

  // R9
  undefined_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we && !known_addr) |=> (acc_rdata == '0));

  // R10
  read_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we) |=> acc_rvalid);

  // R10
  no_spurious_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_we) |=> !acc_rvalid);
endmodule

bind dmairq_bank dmairq_chk #(
  .NUM_CH(NUM_CH), .CH_PER_REG(CH_PER_REG), .SLOT_W(SLOT_W),
  .ADDR_W(ADDR_W), .NUM_REG(NUM_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ev_half(ev_half), .ev_desc(ev_desc), .ev_chain(ev_chain),
  .ch_active(ch_active), .acc_en(acc_en), .acc_we(acc_we),
  .acc_addr(acc_addr), .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid),
  .irq(irq), .pend_words(pend_words)
);

// File: tb/dmairq_bank_test.sv
`timescale 1ns/1ps
module dmairq_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ev_half, ev_desc, ev_chain, ch_active;
  logic        acc_en, acc_we;
  logic [7:0]  acc_addr;
  logic [31:0] acc_wdata;
  logic [31:0] acc_rdata;
  logic        acc_rvalid, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam logic [31:0] MASK = 32'h7777_7777;
  logic [31:0] m_en [2];
  logic [31:0] m_pend [2];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  dmairq_bank uut (
    .clk(clk), .rst_n(rst_n),
    .ev_half(ev_half), .ev_desc(ev_desc), .ev_chain(ev_chain),
    .ch_active(ch_active), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_rvalid(acc_rvalid), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [7:0] a);
    case (a)
      8'h00:   return m_en[0];
      8'h04:   return m_en[1];
      8'h10:   return m_pend[0];
      8'h14:   return m_pend[1];
      8'h30:   return {16'h0, ch_active};
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model_set(logic [15:0] h, logic [15:0] d, logic [15:0] c);
    for (int ch = 0; ch < 16; ch++) begin
      if (h[ch]) m_pend[ch/8][4*(ch%8) + 0] = 1'b1;
      if (d[ch]) m_pend[ch/8][4*(ch%8) + 1] = 1'b1;
      if (c[ch]) m_pend[ch/8][4*(ch%8) + 2] = 1'b1;
    end
  endfunction

  function automatic void model_write(logic [7:0] a, logic [31:0] d);
    case (a)
      8'h00: m_en[0] = d & MASK;
      8'h04: m_en[1] = d & MASK;
      8'h10: m_pend[0] = m_pend[0] & ~d;
      8'h14: m_pend[1] = m_pend[1] & ~d;
      default: ;
    endcase
  endfunction

  task automatic rd(logic [7:0] a, string tag);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
    model_write(a, d);
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic pulse(logic [15:0] h, logic [15:0] d, logic [15:0] c);
    @(negedge clk);
    ev_half = h; ev_desc = d; ev_chain = c;
    model_set(h, d, c);
    @(negedge clk);
    ev_half = '0; ev_desc = '0; ev_chain = '0;
  endtask

  task automatic irq_chk(string tag);
    chk(tag, {31'b0, irq},
        {31'b0, |((m_en[0] & m_pend[0]) | (m_en[1] & m_pend[1]))});
  endtask

  // response monitor: pops one expected word per read strobe
  always @(negedge clk) begin
    if (rst_n === 1'b1 && acc_rvalid === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R10 unexpected response actual=%h expected=none", acc_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, acc_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ev_half = '0; ev_desc = '0; ev_chain = '0; ch_active = '0;
    acc_en = 1'b0; acc_we = 1'b0; acc_addr = '0; acc_wdata = '0;
    m_en[0] = '0; m_en[1] = '0; m_pend[0] = '0; m_pend[1] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 rvalid after reset", {31'b0, acc_rvalid}, 32'h0);
    rd(8'h00, "R1 en0 reset");
    rd(8'h04, "R1 en1 reset");
    rd(8'h10, "R1 pend0 reset");
    rd(8'h14, "R1 pend1 reset");
    rd(8'h30, "R1 status reset");

    // R2 R3 event placement, enable still zero
    pulse(16'h0001, 16'h0000, 16'h0000);
    rd(8'h10, "R2 half ch0 -> pend0 bit0");
    irq_chk("R3 irq low with enables clear");
    pulse(16'h0000, 16'h0080, 16'h0800);
    rd(8'h10, "R2 desc ch7 -> pend0 bit29");
    rd(8'h14, "R2 chain ch11 -> pend1 bit14");
    pulse(16'h8000, 16'h8000, 16'h8000);
    rd(8'h14, "R2 all kinds ch15 -> pend1 bits30:28");
    irq_chk("R3 irq still low");

    // R4 enable write and reserved bits
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, "R4 en0 reserved bits read zero");
    irq_chk("R7 irq high once enabled");

    // R5 write-one-to-clear
    wr(8'h10, 32'h0000_0001);
    rd(8'h10, "R5 clear bit0 only");
    irq_chk("R7 irq with bit29 still pending");
    wr(8'h10, 32'h2000_0000);
    rd(8'h10, "R5 clear bit29");
    irq_chk("R7 irq low after clear");

    // R6 event and clear in the same cycle
    @(negedge clk);
    ev_half = 16'h0001;
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = 8'h10; acc_wdata = 32'h0000_0001;
    model_write(8'h10, 32'h0000_0001);
    model_set(16'h0001, 16'h0, 16'h0);
    @(negedge clk);
    ev_half = '0; acc_en = 1'b0; acc_we = 1'b0;
    rd(8'h10, "R6 event wins over clear");
    irq_chk("R7 irq high after clash");
    wr(8'h10, 32'hFFFF_FFFF);
    irq_chk("R7 irq low after full clear");

    // R7 high word enable path
    wr(8'h04, 32'h0000_0400);
    rd(8'h04, "R4 en1 stored");
    irq_chk("R7 irq low: ch10 chain not pending");
    pulse(16'h0000, 16'h0000, 16'h0400);
    irq_chk("R7 irq from ch10 chain");
    wr(8'h14, 32'h0000_0400);
    irq_chk("R7 irq low after ch10 clear");
    rd(8'h14, "R5 pend1 other bits kept");

    // R8 status word
    ch_active = 16'hA5C3;
    rd(8'h30, "R8 status reflects active");
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, "R8 status after write");
    rd(8'h00, "R8 en0 unchanged by status write");
    rd(8'h14, "R8 pend1 unchanged by status write");

    // R9 undefined offsets
    rd(8'h08, "R9 read 0x08");
    rd(8'h20, "R9 read 0x20");
    rd(8'h34, "R9 read 0x34");
    wr(8'h08, 32'h0000_0000);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h00, "R9 en0 unchanged");
    rd(8'h04, "R9 en1 unchanged");
    rd(8'h14, "R9 pend1 unchanged");

    repeat (3) @(negedge clk);
    chk("R10 all responses arrived", 32'(exp_q.size()), 32'h0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule